// File: doc/BRIEF.md
# Memory-Mapped Address Decoder with Console Ports

This block sits between a small 16-bit processor core and the storage and I/O behind it. It takes one read or write request per cycle and sends it to one of three places, chosen by the address. The lower half of the 16-bit space holds a byte-wide program ROM. Each ROM byte is returned zero-extended to 16 bits. A 16 K-address window above that holds a word-wide data RAM. Three fixed addresses near 0xC000 act as console ports.

A write to the numeric port or to the character port produces a one-cycle console output strobe. The strobe carries a kind bit that says whether the value is a number or a character. A read of the input port holds the core with a stall until a character is offered. It then takes exactly one character. A read of any address outside these regions returns zero, and a write to one does nothing. The ROM is loaded through a separate preload port before the core runs.

The ROM and RAM depths are parameters. Address bits above the implemented depth are not decoded, so a smaller RAM repeats across the window.

Top module: `mmio_addr_decoder`

## Requirements
- R1: A read of an address in 0x0000..0x7FFF returns the ROM byte at index (address mod ROM depth). The byte is zero-extended, so bits 15:8 of the read data are 0.
- R2: A read of an address in 0x8000..0xBFFF returns the RAM word at index ((address - 0x8000) mod RAM depth). A write to such an address stores the full 16-bit value at that index.
- R3: A write to an address below 0x8000 changes no ROM byte. A later read of the same address returns the preloaded value.
- R4: A write to 0xC000 drives con_out_valid high for exactly one cycle, in the cycle after the write is accepted. During that cycle con_out_kind is 0 (numeric) and con_out_data equals the written value.
- R5: A write to 0xC001 drives a one-cycle con_out_valid pulse with con_out_kind 1 (character). con_out_data then carries only the low byte of the written value, with bits 15:8 equal to 0.
- R6: While a read of 0xC002 is requested and con_in_valid is low, req_stall is high in the same cycle and con_in_ready stays low.
- R7: When a read of 0xC002 is requested and con_in_valid is high, con_in_ready is high for that cycle only and exactly one character is taken. The read returns that character zero-extended.
- R8: A read of an address in 0xC000..0xFFFF other than 0xC002 returns 0. A write to an address in 0xC002..0xFFFF produces no console output and changes no RAM word.
- R9: For each accepted read, rsp_valid is high for one cycle, in the cycle after acceptance, with rsp_rdata holding the result. An accepted write never raises rsp_valid.
- R10: During and right after reset, rsp_valid, con_out_valid, req_stall and rsp_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| req_stall | output | 1 | Request held this cycle (console input not ready) |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_rdata | output | 16 | Read data |
| con_out_valid | output | 1 | Console output strobe |
| con_out_kind | output | 1 | 0 = numeric, 1 = character |
| con_out_data | output | 16 | Console output value |
| con_in_valid | input | 1 | A console input character is offered |
| con_in_data | input | 8 | Offered character |
| con_in_ready | output | 1 | Offered character is taken this cycle |
| rom_load_en | input | 1 | ROM preload write enable |
| rom_load_addr | input | ROM_AW | ROM preload byte index |
| rom_load_data | input | 8 | ROM preload byte |

## Verification
The assertions assume that the core keeps a stalled request steady until the stall drops. They also assume that the ROM preload port is idle whenever the core issues requests. The bench meets both assumptions. It preloads the whole ROM first and only then starts any request. It changes the request inputs only on falling edges. During a console-input wait it holds the address and direction fixed, while it raises con_in_valid at a time of its own choosing.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  typedef enum logic [2:0] {
    RG_ROM     = 3'd0,
    RG_RAM     = 3'd1,
    RG_OUT_NUM = 3'd2,
    RG_OUT_CHR = 3'd3,
    RG_IN_CHR  = 3'd4,
    RG_NONE    = 3'd5
  } region_e;

  localparam logic [15:0] ADDR_RAM_BASE = 16'h8000;
  localparam logic [15:0] ADDR_IO_BASE  = 16'hC000;
  localparam logic [15:0] ADDR_OUT_NUM  = 16'hC000;
  localparam logic [15:0] ADDR_OUT_CHR  = 16'hC001;
  localparam logic [15:0] ADDR_IN_CHR   = 16'hC002;

  localparam logic KIND_NUM = 1'b0;
  localparam logic KIND_CHR = 1'b1;

  // Map an address to the region that serves it.
  function automatic region_e classify(input logic [15:0] a);
    region_e r;
    if (a < ADDR_RAM_BASE)        r = RG_ROM;
    else if (a < ADDR_IO_BASE)    r = RG_RAM;
    else if (a == ADDR_OUT_NUM)   r = RG_OUT_NUM;
    else if (a == ADDR_OUT_CHR)   r = RG_OUT_CHR;
    else if (a == ADDR_IN_CHR)    r = RG_IN_CHR;
    else                          r = RG_NONE;
    return r;
  endfunction

  // Zero-extend a byte to a word.
  function automatic logic [15:0] zext8(input logic [7:0] b);
    return {8'h00, b};
  endfunction

  // Payload sent for a character write: the low byte only.
  function automatic logic [15:0] chr_payload(input logic [15:0] w);
    return zext8(w[7:0]);
  endfunction

endpackage

// File: rtl/mmio_region_decode.sv
module mmio_region_decode
  import mmio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic        con_in_valid,
  output region_e     region,
  output logic        rd_accept,
  output logic        wr_accept,
  output logic        stall,
  output logic        ram_we,
  output logic        mem_re,
  output logic        out_fire,
  output logic        out_kind,
  output logic        in_take
);

  logic is_read;
  logic in_port_read;

  always_comb begin
    region       = classify(req_addr);
    is_read      = req_valid && !req_write;
    in_port_read = is_read && (region == RG_IN_CHR);
    stall        = in_port_read && !con_in_valid;
    in_take      = in_port_read && con_in_valid;
    rd_accept    = is_read && !stall;
    wr_accept    = req_valid && req_write;
    ram_we       = wr_accept && (region == RG_RAM);
    mem_re       = rd_accept && ((region == RG_ROM) || (region == RG_RAM));
    out_fire     = wr_accept && ((region == RG_OUT_NUM) || (region == RG_OUT_CHR));
    out_kind     = (region == RG_OUT_CHR) ? KIND_CHR : KIND_NUM;
  end

  // R6: a stall is only raised for a console-input read
  a_r6_stall_only_input: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (req_valid && !req_write && req_addr == ADDR_IN_CHR && !con_in_valid));

  // R7: a character is taken only when offered and the request is not held
  a_r7_take_when_offered: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |-> (con_in_valid && rd_accept && !stall));

  // R3: the ROM range never produces a RAM write
  a_r3_rom_no_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr < ADDR_RAM_BASE) |-> !ram_we);

  // R8: writes to unmapped space trigger neither storage nor output
  a_r8_unmapped_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr >= ADDR_IN_CHR) |-> (!ram_we && !out_fire));

endmodule

// File: rtl/mmio_rom.sv
module mmio_rom #(
  parameter int ROM_AW = 9
) (
  input  logic              clk,
  input  logic              load_en,
  input  logic [ROM_AW-1:0] load_addr,
  input  logic [7:0]        load_data,
  input  logic              rd_en,
  input  logic [ROM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ROM_AW;

  logic [7:0] mem [DEPTH];

  // Only the preload port can change contents.
  always_ff @(posedge clk) begin
    if (load_en) mem[load_addr] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
  parameter int RAM_AW = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end

  // R2: one request per cycle, never a read and a write together
  a_r2_single_access: assert property (@(posedge clk) !(we && re));

endmodule

// File: rtl/mmio_console.sv
module mmio_console
  import mmio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        out_fire,
  input  logic        out_kind,
  input  logic [15:0] out_value,
  input  logic        in_take,
  input  logic [7:0]  in_char,
  output logic        con_out_valid,
  output logic        con_out_kind,
  output logic [15:0] con_out_data,
  output logic [15:0] in_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      con_out_valid <= 1'b0;
      con_out_kind  <= KIND_NUM;
      con_out_data  <= '0;
      in_word       <= '0;
    end else begin
      con_out_valid <= out_fire;
      if (out_fire) begin
        con_out_kind <= out_kind;
        con_out_data <= (out_kind == KIND_CHR) ? chr_payload(out_value) : out_value;
      end
      if (in_take) in_word <= zext8(in_char);
    end
  end

  // R5: a character strobe carries only a byte
  a_r5_chr_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
    (con_out_valid && con_out_kind == KIND_CHR) |-> (con_out_data[15:8] == 8'h00));

endmodule

// File: rtl/mmio_addr_decoder.sv
module mmio_addr_decoder
  import mmio_pkg::*;
#(
  parameter int ROM_AW = 9,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [15:0]       req_wdata,
  output logic              req_stall,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              con_out_valid,
  output logic              con_out_kind,
  output logic [15:0]       con_out_data,
  input  logic              con_in_valid,
  input  logic [7:0]        con_in_data,
  output logic              con_in_ready,
  input  logic              rom_load_en,
  input  logic [ROM_AW-1:0] rom_load_addr,
  input  logic [7:0]        rom_load_data
);

  region_e     region;
  region_e     region_q;
  logic        rd_accept, wr_accept, stall, ram_we, mem_re, out_fire, out_kind, in_take;
  logic        rd_pend_q;
  logic [7:0]  rom_byte;
  logic [15:0] ram_word;
  logic [15:0] in_word;

  mmio_region_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .con_in_valid (con_in_valid),
    .region       (region),
    .rd_accept    (rd_accept),
    .wr_accept    (wr_accept),
    .stall        (stall),
    .ram_we       (ram_we),
    .mem_re       (mem_re),
    .out_fire     (out_fire),
    .out_kind     (out_kind),
    .in_take      (in_take)
  );

  mmio_rom #(.ROM_AW(ROM_AW)) u_rom (
    .clk       (clk),
    .load_en   (rom_load_en),
    .load_addr (rom_load_addr),
    .load_data (rom_load_data),
    .rd_en     (mem_re && region == RG_ROM),
    .rd_addr   (req_addr[ROM_AW-1:0]),
    .rd_data   (rom_byte)
  );

  mmio_ram #(.RAM_AW(RAM_AW), .DATA_W(16)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (mem_re && region == RG_RAM),
    .addr  (req_addr[RAM_AW-1:0]),
    .wdata (req_wdata),
    .rdata (ram_word)
  );

  mmio_console u_con (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_fire      (out_fire),
    .out_kind      (out_kind),
    .out_value     (req_wdata),
    .in_take       (in_take),
    .in_char       (con_in_data),
    .con_out_valid (con_out_valid),
    .con_out_kind  (con_out_kind),
    .con_out_data  (con_out_data),
    .in_word       (in_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      region_q  <= RG_NONE;
    end else begin
      rd_pend_q <= rd_accept;
      if (rd_accept) region_q <= region;
    end
  end

  always_comb begin
    unique case (region_q)
      RG_ROM:    rsp_rdata = zext8(rom_byte);
      RG_RAM:    rsp_rdata = ram_word;
      RG_IN_CHR: rsp_rdata = in_word;
      default:   rsp_rdata = '0;
    endcase
    if (!rd_pend_q) rsp_rdata = '0;
  end

  assign rsp_valid    = rd_pend_q;
  assign req_stall    = stall;
  assign con_in_ready = in_take;

  // R9: a response follows an accepted read and nothing else
  a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write && !req_stall));

  // R4: every console strobe follows a write to an output port
  a_r4_out_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    con_out_valid |-> $past(req_valid && req_write &&
                            (req_addr == ADDR_OUT_NUM || req_addr == ADDR_OUT_CHR)));

  // R1: ROM reads are zero-extended
  a_r1_rom_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && region_q == RG_ROM) |-> (rsp_rdata[15:8] == 8'h00));

  // R7: an input read answers with the zero-extended character
  a_r7_in_zext: assert property (@(posedge clk) disable iff (!rst_n)
    $past(con_in_ready) |-> (rsp_valid && rsp_rdata == {8'h00, $past(con_in_data)}));

endmodule

// File: tb/tb_mmio_addr_decoder.sv
module tb_mmio_addr_decoder;

  localparam int ROM_AW = 9;
  localparam int RAM_AW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [15:0]       req_addr = '0;
  logic [15:0]       req_wdata = '0;
  logic              req_stall, rsp_valid, con_out_valid, con_out_kind, con_in_ready;
  logic [15:0]       rsp_rdata, con_out_data;
  logic              con_in_valid = 1'b0;
  logic [7:0]        con_in_data = '0;
  logic              rom_load_en = 1'b0;
  logic [ROM_AW-1:0] rom_load_addr = '0;
  logic [7:0]        rom_load_data = '0;

  int checks = 0;
  int errors = 0;
  int takes  = 0;
  int outs   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  mmio_addr_decoder #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_stall(req_stall),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .con_out_valid(con_out_valid),
    .con_out_kind(con_out_kind), .con_out_data(con_out_data),
    .con_in_valid(con_in_valid), .con_in_data(con_in_data), .con_in_ready(con_in_ready),
    .rom_load_en(rom_load_en), .rom_load_addr(rom_load_addr), .rom_load_data(rom_load_data)
  );

  always @(posedge clk) begin
    if (con_in_ready) takes++;
    if (con_out_valid) outs++;
  end

  function automatic logic [7:0] rom_pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [15:0] d, output logic v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid; d = rsp_rdata;
  endtask

  task automatic t_reset;
    chk("R10 rsp_valid", 16'(rsp_valid), 16'h0);
    chk("R10 con_out_valid", 16'(con_out_valid), 16'h0);
    chk("R10 req_stall", 16'(req_stall), 16'h0);
    chk("R10 rsp_rdata", rsp_rdata, 16'h0);
  endtask

  task automatic t_rom;
    logic [15:0] d; logic v;
    int idx [4] = '{0, 1, 200, 511};
    foreach (idx[k]) begin
      do_read(16'(idx[k]), d, v);
      chk("R9 rom rsp_valid", 16'(v), 16'h1);
      chk("R1 rom read", d, {8'h00, rom_pat(idx[k])});
    end
    do_read(16'h7FFF, d, v);
    chk("R1 rom alias top", d, {8'h00, rom_pat(16'h7FFF % 512)});
    @(negedge clk);
    chk("R9 rsp one cycle", 16'(rsp_valid), 16'h0);
  endtask

  task automatic t_rom_ro;
    logic [15:0] d; logic v;
    do_write(16'h0003, 16'hBEEF);
    chk("R9 no rsp on write", 16'(rsp_valid), 16'h0);
    do_read(16'h0003, d, v);
    chk("R3 rom unchanged", d, {8'h00, rom_pat(3)});
  endtask

  task automatic t_ram;
    logic [15:0] d; logic v;
    do_write(16'h8005, 16'h1234);
    do_write(16'h80FF, 16'hA5C3);
    do_read(16'h8005, d, v);
    chk("R2 ram read", d, 16'h1234);
    do_read(16'h80FF, d, v);
    chk("R2 ram last word", d, 16'hA5C3);
    do_read(16'h8105, d, v);
    chk("R2 ram alias", d, 16'h1234);
    do_write(16'hBF05, 16'h0F0F);
    do_read(16'h8005, d, v);
    chk("R2 ram alias write", d, 16'h0F0F);
  endtask

  task automatic t_out;
    int o0;
    do_write(16'hC000, 16'hFEDC);
    chk("R4 valid", 16'(con_out_valid), 16'h1);
    chk("R4 kind", 16'(con_out_kind), 16'h0);
    chk("R4 data", con_out_data, 16'hFEDC);
    @(negedge clk);
    chk("R4 pulse ends", 16'(con_out_valid), 16'h0);
    do_write(16'hC001, 16'h9A41);
    chk("R5 valid", 16'(con_out_valid), 16'h1);
    chk("R5 kind", 16'(con_out_kind), 16'h1);
    chk("R5 data", con_out_data, 16'h0041);
    @(negedge clk);
    o0 = outs;
    do_write(16'hC002, 16'h1111);
    do_write(16'hC003, 16'h2222);
    do_write(16'hFFFF, 16'h3333);
    @(negedge clk);
    chk("R8 no output on unmapped write", 16'(outs - o0), 16'h0);
  endtask

  task automatic t_unmapped;
    logic [15:0] d; logic v;
    do_read(16'hC000, d, v);
    chk("R8 read C000", d, 16'h0);
    chk("R9 unmapped rsp_valid", 16'(v), 16'h1);
    do_read(16'hD123, d, v);
    chk("R8 read D123", d, 16'h0);
    do_read(16'h8005, d, v);
    chk("R8 ram untouched", d, 16'h0F0F);
  endtask

  task automatic t_input;
    int t0;
    t0 = takes;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'hC002;
    #1;
    chk("R6 stall", 16'(req_stall), 16'h1);
    chk("R6 no ready", 16'(con_in_ready), 16'h0);
    repeat (3) @(negedge clk);
    chk("R6 still stalled", 16'(req_stall), 16'h1);
    chk("R9 no rsp while stalled", 16'(rsp_valid), 16'h0);
    con_in_valid = 1; con_in_data = 8'hC7;
    #1;
    chk("R7 ready", 16'(con_in_ready), 16'h1);
    chk("R7 stall drops", 16'(req_stall), 16'h0);
    @(negedge clk);
    req_valid = 0; con_in_valid = 0; con_in_data = 8'h55;
    chk("R7 rsp_valid", 16'(rsp_valid), 16'h1);
    chk("R7 char", rsp_rdata, 16'h00C7);
    chk("R7 one take", 16'(takes - t0), 16'h1);
    @(negedge clk);
    con_in_valid = 1;
    #1;
    chk("R7 no take without read", 16'(con_in_ready), 16'h0);
    @(negedge clk);
    con_in_valid = 0;
    chk("R7 still one take", 16'(takes - t0), 16'h1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      rom_load_en = 1; rom_load_addr = ROM_AW'(i); rom_load_data = rom_pat(i);
    end
    @(negedge clk);
    rom_load_en = 0;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rom();
    t_rom_ro();
    t_ram();
    t_out();
    t_unmapped();
    t_input();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule